// File: doc/BRIEF.md
# Camera YCbCr Pixel Word Packer

This block takes a 4:2:2 video stream from a camera port and packs it into 32-bit words for storage. The camera side has a horizontal sync and a vertical sync. It also has an 8-bit luma bus and an 8-bit chroma bus. The chroma bus carries Cb on even pixels and Cr on odd pixels of each line. The block runs on the pixel clock. A pixel is captured on every clock edge at which both the enable input and horizontal sync are high.

A mode input picks one of two word formats:

- **Planar:** separate words of four luma samples, four Cb samples or four Cr samples.
- **Interleaved:** each word carries two full pixels.

Finished words pass through a small FIFO to a valid/ready write port. Each word has a 2-bit tag that names its kind. A one-cycle interrupt pulse marks the end of each frame, once every word of the frame has been accepted. A sticky flag reports any word lost because the FIFO was full.

Top module: `cam_yuv_packer`

## Requirements
- R1: After reset `wr_valid`, `frame_irq` and `overflow` are 0.
- R2: Planar mode (`interleave`=0) emits a luma word with tag 0 after every 4 captured pixels of a line. Byte k (bits 8k+7:8k) holds the k-th of those samples, so the earliest sample sits in bits 7:0.
- R3: Planar mode emits a Cb word (tag 1) and a Cr word (tag 2) for every 8 captured pixels. Byte k of the Cb word is the chroma sample of pixel 2k of the group. Byte k of the Cr word is the chroma sample of pixel 2k+1. Within a group the emit order is: luma word, then Cb word, then Cr word.
- R4: Interleaved mode (`interleave`=1) emits one word with tag 3 per pixel pair. From bits 31:24 down to bits 7:0 it holds: odd luma, odd chroma (Cr), even luma, even chroma (Cb).
- R5: When horizontal sync falls and a word is partly filled, that word is emitted with its unused bytes set to zero. In planar mode the luma word goes first, then the Cb and Cr words.
- R6: After vertical sync falls, `frame_irq` is high for exactly one cycle, once the FIFO is empty and nothing more is being produced. No word is then left pending.
- R7: `overflow` is set and stays set if a word completes while the FIFO has no room; that word is dropped. `overflow` clears at the next rising edge of vertical sync.
- R8: While `enable` is 0 no pixel is captured, no word is produced and no interrupt is raised.
- R9: A word offered on the write port keeps its data and tag until `wr_ready` accepts it. No word is lost or reordered while the FIFO has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Global enable. Keep it low at reset. |
| interleave | input | 1 | 0: planar format, 1: interleaved format |
| hsync | input | 1 | High while the pixels of a line are active |
| vsync | input | 1 | High during a frame |
| luma | input | 8 | Luma sample |
| chroma | input | 8 | Chroma sample: Cb on even pixels, Cr on odd pixels |
| wr_ready | input | 1 | The sink accepts the offered word |
| wr_valid | output | 1 | A word is offered |
| wr_data | output | 32 | Packed word |
| wr_tag | output | 2 | Word kind: 0 luma, 1 Cb, 2 Cr, 3 interleaved |
| frame_irq | output | 1 | One-cycle pulse when the frame has drained |
| overflow | output | 1 | Sticky flag: a word was lost to a full FIFO |

## Verification
Each kind of internal fault shows up at the ports in a predictable way:

- **Wrong byte lane or pixel counter:** the word comes out with bytes in the wrong positions, or a word arrives early or late. The scoreboard catches this on the next word handed off.
- **Accumulator not cleared:** leftover bytes from an earlier word appear in the zero padding of the next flushed word at the end of the line.
- **Bad FIFO pointer or count:** words repeat, drop out or change order within a few words.
- **Bad pending-frame state:** the interrupt fires too early, with words still expected, or never fires. Either is caught within the short wait after the end of the frame.

// File: rtl/cam_yuv_packer.sv
`timescale 1ns/1ps
module cam_yuv_packer #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        interleave,
  input  logic        hsync,
  input  logic        vsync,
  input  logic [7:0]  luma,
  input  logic [7:0]  chroma,
  input  logic        wr_ready,
  output logic        wr_valid,
  output logic [31:0] wr_data,
  output logic [1:0]  wr_tag,
  output logic        frame_irq,
  output logic        overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          hs_q, vs_q, pend, irq_q, ovf_q;
  logic [2:0]    px;
  logic [31:0]   y_acc, cb_acc, cr_acc;
  logic [33:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, free;
  logic [33:0]   pw [4];
  logic [1:0]    np, nok;

  wire cap   = enable & hsync;
  wire flush = enable & hs_q & ~hsync;
  wire sof   = enable & vsync & ~vs_q;
  wire eof   = enable & ~vsync & vs_q;
  wire pop   = wr_valid & wr_ready;

  wire [31:0] y_ins  = y_acc | ({24'd0, luma} << {px[1:0], 3'b000});
  wire [31:0] c_byte = {24'd0, chroma} << {px[2:1], 3'b000};
  wire [31:0] cb_ins = px[0] ? cb_acc : (cb_acc | c_byte);
  wire [31:0] cr_ins = px[0] ? (cr_acc | c_byte) : cr_acc;
  wire [31:0] i_ins  = y_acc | ({16'd0, luma, chroma} << {px[0], 4'b0000});

  always_comb begin
    pw = '{default: '0};
    np = 2'd0;
    if (!sof) begin
      if (cap && !interleave) begin
        if (px[1:0] == 2'd3) begin pw[np] = {2'd0, y_ins}; np = np + 2'd1; end
        if (px == 3'd7) begin
          pw[np] = {2'd1, cb_ins}; np = np + 2'd1;
          pw[np] = {2'd2, cr_ins}; np = np + 2'd1;
        end
      end else if (cap && interleave) begin
        if (px[0]) begin pw[0] = {2'd3, i_ins}; np = 2'd1; end
      end else if (flush && !interleave) begin
        if (px[1:0] != 2'd0) begin pw[np] = {2'd0, y_acc}; np = np + 2'd1; end
        if (px != 3'd0) begin
          pw[np] = {2'd1, cb_acc}; np = np + 2'd1;
          pw[np] = {2'd2, cr_acc}; np = np + 2'd1;
        end
      end else if (flush && interleave && px[0]) begin
        pw[0] = {2'd3, y_acc}; np = 2'd1;
      end
    end
  end

  assign free = CW'(DEPTH) - cnt;
  assign nok  = (CW'(np) > free) ? free[1:0] : np;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; px <= '0;
      y_acc <= '0; cb_acc <= '0; cr_acc <= '0;
      wp <= '0; rp <= '0; cnt <= '0;
      pend <= 1'b0; irq_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (sof || flush) begin
        px <= '0; y_acc <= '0; cb_acc <= '0; cr_acc <= '0;
      end else if (cap) begin
        px <= px + 3'd1;
        if (interleave) begin
          y_acc <= px[0] ? '0 : i_ins;
        end else begin
          y_acc  <= (px[1:0] == 2'd3) ? '0 : y_ins;
          cb_acc <= (px == 3'd7) ? '0 : cb_ins;
          cr_acc <= (px == 3'd7) ? '0 : cr_ins;
        end
      end
      for (int i = 0; i < 3; i++)
        if (2'(i) < nok) mem[wp + AW'(i)] <= pw[i];
      wp  <= wp + AW'(nok);
      rp  <= rp + AW'(pop);
      cnt <= cnt + CW'(nok) - CW'(pop);
      if (sof) ovf_q <= 1'b0;
      else if (nok != np) ovf_q <= 1'b1;
      irq_q <= 1'b0;
      if (sof) pend <= 1'b0;
      else if (eof) pend <= 1'b1;
      else if (pend && cnt == '0 && np == 2'd0) begin
        pend  <= 1'b0;
        irq_q <= 1'b1;
      end
    end
  end

  assign wr_valid  = (cnt != '0);
  assign wr_data   = mem[rp][31:0];
  assign wr_tag    = mem[rp][33:32];
  assign frame_irq = irq_q;
  assign overflow  = ovf_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_tag)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq); // R6
  AST_IRQ_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> !wr_valid); // R6
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !overflow); // R7
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> np == 2'd0); // R8
endmodule

// File: tb/cam_yuv_packer_tb.sv
`timescale 1ns/1ps
module cam_yuv_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, interleave = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, wr_ready = 1'b1;
  logic [7:0] luma = '0, chroma = '0;
  logic wr_valid, frame_irq, overflow;
  logic [31:0] wr_data;
  logic [1:0] wr_tag;

  int checks = 0, errors = 0, irq_cnt = 0, cyc = 0, rdy_mode = 0;
  bit sb_on = 1'b1, model_on = 1'b1, done = 1'b0;
  logic [33:0] exp_q[$];
  string req_q[$];

  cam_yuv_packer #(.DEPTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .interleave(interleave),
    .hsync(hsync), .vsync(vsync), .luma(luma), .chroma(chroma),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_tag(wr_tag), .frame_irq(frame_irq), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (cyc % 3 != 0);
      default: wr_ready = 1'b0;
    endcase
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (frame_irq) begin
      irq_cnt++;
      chk(exp_q.size() == 0, "R6", "irq with words pending", exp_q.size(), 0);
    end
    if (wr_valid && wr_ready && sb_on) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected word", {wr_tag, wr_data}, 0);
      else begin
        logic [33:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({wr_tag, wr_data} === e, r, "word", {wr_tag, wr_data}, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] ypx(logic [7:0] b, int i);
    return b + 8'(i);
  endfunction
  function automatic logic [7:0] cpx(logic [7:0] b, int i);
    return (b ^ 8'h5A) + 8'(3 * i);
  endfunction

  task automatic push(logic [1:0] t, logic [31:0] d, string r);
    exp_q.push_back({t, d});
    req_q.push_back(r);
  endtask

  task automatic line(int n, logic [7:0] b);
    if (model_on && enable) begin
      if (!interleave) begin
        for (int s = 0; s < n; s += 8) begin
          for (int h = 0; h < 8; h += 4) begin
            if (s + h < n) begin
              logic [31:0] w = '0;
              for (int k = 0; k < 4; k++)
                if (s + h + k < n) w[8*k +: 8] = ypx(b, s + h + k);
              push(2'd0, w, (s + h + 4 > n) ? "R5" : "R2");
            end
          end
          begin
            logic [31:0] cb = '0, cr = '0;
            for (int k = 0; k < 4; k++) begin
              if (s + 2*k < n) cb[8*k +: 8] = cpx(b, s + 2*k);
              if (s + 2*k + 1 < n) cr[8*k +: 8] = cpx(b, s + 2*k + 1);
            end
            push(2'd1, cb, (s + 8 > n) ? "R5" : "R3");
            push(2'd2, cr, (s + 8 > n) ? "R5" : "R3");
          end
        end
      end else begin
        for (int p = 0; p < n; p += 2) begin
          logic [31:0] w = '0;
          w[7:0] = cpx(b, p);
          w[15:8] = ypx(b, p);
          if (p + 1 < n) begin
            w[23:16] = cpx(b, p + 1);
            w[31:24] = ypx(b, p + 1);
          end
          push(2'd3, w, (p + 1 < n) ? "R4" : "R5");
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      tick();
      hsync = 1'b1; luma = ypx(b, i); chroma = cpx(b, i);
    end
    tick(); hsync = 1'b0;
    repeat (3) tick();
  endtask

  task automatic frame(bit il, int n0, int n1, int n2, logic [7:0] b);
    int start;
    interleave = il;
    tick(); vsync = 1'b1;
    tick(); tick();
    line(n0, b);
    if (n1 > 0) line(n1, b + 8'h40);
    if (n2 > 0) line(n2, b + 8'h80);
    tick(); vsync = 1'b0;
    start = irq_cnt;
    repeat (60) tick();
    chk(irq_cnt - start == (enable ? 1 : 0), enable ? "R6" : "R8", "irq count",
        irq_cnt - start, enable ? 1 : 0);
    chk(exp_q.size() == 0, "R6", "words left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    chk(wr_valid == 1'b0, "R1", "wr_valid in reset", wr_valid, 0);
    rst_n = 1'b1;
    tick();
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
    chk(frame_irq == 1'b0, "R1", "frame_irq after reset", frame_irq, 0);
    chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);

    enable = 1'b1;
    frame(1'b0, 16, 16, 0, 8'h10);
    rdy_mode = 1;
    frame(1'b0, 13, 6, 1, 8'h21);
    frame(1'b1, 8, 7, 0, 8'h37);
    frame(1'b1, 1, 0, 0, 8'hC3);

    rdy_mode = 0;
    enable = 1'b0;
    frame(1'b0, 8, 8, 0, 8'h55);
    chk(wr_valid == 1'b0, "R8", "valid while disabled", wr_valid, 0);

    enable = 1'b1;
    rdy_mode = 2;
    sb_on = 1'b0; model_on = 1'b0;
    interleave = 1'b0;
    tick(); vsync = 1'b1; tick();
    line(32, 8'h02);
    chk(overflow == 1'b1, "R7", "overflow set", overflow, 1);
    rdy_mode = 0;
    repeat (20) tick();
    vsync = 1'b0;
    repeat (20) tick();
    chk(overflow == 1'b1, "R7", "overflow sticky", overflow, 1);
    chk(wr_valid == 1'b0, "R9", "fifo drained", wr_valid, 0);
    sb_on = 1'b1; model_on = 1'b1;
    vsync = 1'b1;
    tick(); tick();
    chk(overflow == 1'b0, "R7", "overflow cleared", overflow, 0);
    vsync = 1'b0;
    repeat (10) tick();
    frame(1'b0, 12, 0, 0, 8'h66);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule